// File: doc/BRIEF.md
# Router Supply and Pipeline-Depth Controller

This controller sits beside one router of a mesh network and picks two things each cycle: whether the router runs from the high or the low supply rail, and whether it forwards in a short one-cycle pipeline or a long two-cycle pipeline. With no traffic it parks the router on the low rail with the long pipeline. Demand moves it to the high rail with the short pipeline. The short pipeline has the longer critical path, so it is only legal once the high rail has settled. The controller always orders the steps to respect this. It raises the rail, waits for it to settle, then shortens the pipeline. It lengthens the pipeline before it lowers the rail.

Demand comes from several sources: early-warning notices sent by routers two hops upstream, packet heads arriving at the router's inputs, injection requests from the local core, and non-empty input buffers. The controller sends its own early-warning notice one cycle after a packet head arrives or the local core injects. Downstream routers can then wake before that packet reaches them. A packet from the local core has no early warning, so its first hop leaves on the long pipeline while the rail settles.

A hot-die flag forces the high rail with the long pipeline. A performance-policy input keeps the router on the high rail with the short pipeline whenever the die is cool. The router drops back to the low rail only after a programmable idle span, which defaults to the 23-cycle break-even time of a rail round trip. An arrival of new demand during that descent cancels it.

Top module: `vp_power_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `vdd_high`, `pipe_short` and `notice_out` are all 0.
- R2: Any demand input (a bit of `notice_in`, `pkt_arrive` or `buf_nonempty`, or `inject_req`) seen at a clock edge makes `vdd_high` 1 after that edge, whatever the state.
- R3: From the low rail, the first demand makes `vdd_high` 1 one cycle later. `pipe_short` becomes 1 exactly SETTLE+1 cycles after that demand (3 by default). An injected packet therefore sees the long pipeline on its first hop.
- R4: `pipe_short` is never 1 unless `vdd_high` has been 1 for at least SETTLE consecutive cycles.
- R5: A relax first clears `pipe_short` while `vdd_high` stays 1, and clears `vdd_high` one cycle later.
- R6: If demand was last present in cycle L, `pipe_short` falls in cycle L+IDLE_MIN+2 and `vdd_high` falls in cycle L+IDLE_MIN+3. This holds under the low-power policy on a cool die.
- R7: Demand in the cycle where the pipeline is long and the rail still high restores `pipe_short` 1 one cycle later. Demand in the first cycle after the rail has dropped raises `vdd_high` one cycle later and restarts the settle wait, so `pipe_short` returns SETTLE+1 cycles after the demand.
- R8: With `hot` 1, `pipe_short` is 0 one cycle later and `vdd_high` is 1 and stays 1. When `hot` falls after IDLE_MIN+1 quiet cycles under the low-power policy, `vdd_high` is 0 one cycle later.
- R9: With `perf_policy` 1 and `hot` 0, the router boosts as in R3 and holds the short pipeline with no time limit. When `perf_policy` falls after a long quiet span, `pipe_short` is 0 one cycle later and `vdd_high` is 0 two cycles later.
- R10: `notice_out` is 1 exactly in the cycle after one in which some `pkt_arrive` bit or `inject_req` was 1. Notices received and buffer occupancy do not drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| notice_in | input | NPORT | Early-warning notices from routers two hops upstream, one per input |
| pkt_arrive | input | NPORT | Packet head present at an input this cycle |
| inject_req | input | 1 | Local core requests injection |
| buf_nonempty | input | NPORT | Input buffer holds at least one flit |
| hot | input | 1 | Die temperature flag, 1 when hot |
| perf_policy | input | 1 | 1 selects the performance policy, 0 the low-power policy |
| vdd_high | output | 1 | Supply select, 1 for the high rail |
| pipe_short | output | 1 | Pipeline select, 1 for the one-cycle pipeline |
| notice_out | output | 1 | Early-warning notice to the router two hops downstream |

## Verification
A controller stuck in or skipping a step shows at the two select outputs within one cycle. A missed settle count makes `pipe_short` rise earlier or later than SETTLE+1 cycles after demand. A wrong idle counter moves the relax edge away from L+IDLE_MIN+2. A state that forgets to cancel leaves `vdd_high` low one cycle after a notice. The bench sweeps every demand source and input index, short and long bursts, cancellation at both relax steps, and both override inputs. At every cycle it compares both selects against the cycle numbers the requirements give.

// File: rtl/vp_power_ctrl.sv
module vp_power_ctrl #(
  parameter int NPORT    = 5,
  parameter int SETTLE   = 2,
  parameter int IDLE_MIN = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] notice_in,
  input  logic [NPORT-1:0] pkt_arrive,
  input  logic             inject_req,
  input  logic [NPORT-1:0] buf_nonempty,
  input  logic             hot,
  input  logic             perf_policy,
  output logic             vdd_high,
  output logic             pipe_short,
  output logic             notice_out
);
  localparam int SW = (SETTLE   < 2) ? 1 : $clog2(SETTLE + 1);
  localparam int IW = (IDLE_MIN < 2) ? 1 : $clog2(IDLE_MIN + 1);

  typedef enum logic [2:0] {ST_LOW, ST_UP, ST_HI1, ST_HI2, ST_DOWN} state_t;

  state_t         state, state_nx;
  logic [SW-1:0]  settle_cnt;
  logic [IW-1:0]  idle_cnt;
  logic           busy, idle_ok, settle_done, wake;

  assign busy        = |notice_in | |pkt_arrive | inject_req | |buf_nonempty;
  assign idle_ok     = !busy && (idle_cnt == IW'(IDLE_MIN));
  assign settle_done = settle_cnt == SW'(SETTLE - 1);
  assign wake        = hot || perf_policy || busy;

  always_comb begin
    state_nx = state;
    case (state)
      ST_LOW:  if (wake) state_nx = ST_UP;
      ST_UP:   if (settle_done) state_nx = hot ? ST_HI2 : ST_HI1;
      ST_HI1:  if (hot || (!perf_policy && idle_ok)) state_nx = ST_HI2;
      ST_HI2:  if (!hot) state_nx = (!perf_policy && idle_ok) ? ST_DOWN : ST_HI1;
      ST_DOWN: if (wake) state_nx = ST_UP;
               else if (settle_done) state_nx = ST_LOW;
      default: state_nx = ST_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_LOW;
      settle_cnt <= '0;
      idle_cnt   <= '0;
      notice_out <= 1'b0;
    end else begin
      state      <= state_nx;
      notice_out <= |pkt_arrive | inject_req;
      if (state != state_nx)  settle_cnt <= '0;
      else if (!settle_done)  settle_cnt <= settle_cnt + SW'(1);
      if (busy)                          idle_cnt <= '0;
      else if (idle_cnt != IW'(IDLE_MIN)) idle_cnt <= idle_cnt + IW'(1);
    end
  end

  assign vdd_high   = (state == ST_UP) || (state == ST_HI1) || (state == ST_HI2);
  assign pipe_short = state == ST_HI1;
endmodule

module vp_power_ctrl_chk #(
  parameter int NPORT    = 5,
  parameter int SETTLE   = 2,
  parameter int IDLE_MIN = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] notice_in,
  input logic [NPORT-1:0] pkt_arrive,
  input logic             inject_req,
  input logic [NPORT-1:0] buf_nonempty,
  input logic             hot,
  input logic             vdd_high,
  input logic             pipe_short
);
  logic        demand;
  int unsigned hi_run, quiet_run;

  assign demand = |notice_in | |pkt_arrive | inject_req | |buf_nonempty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run    <= 0;
      quiet_run <= 0;
    end else begin
      hi_run    <= !vdd_high ? 0 : (hi_run < SETTLE ? hi_run + 1 : hi_run);
      quiet_run <= demand ? 0 : (quiet_run < IDLE_MIN ? quiet_run + 1 : quiet_run);
    end
  end

  // R2
  wake_on_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    demand |=> vdd_high);
  // R4
  short_needs_settled_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_short |-> (vdd_high && hi_run >= SETTLE));
  // R5
  lengthen_before_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_high) |-> (!pipe_short && $past(!pipe_short)));
  // R6
  relax_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_high) |-> quiet_run >= IDLE_MIN);
  // R8
  hot_long_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> (!pipe_short && vdd_high));
endmodule

bind vp_power_ctrl vp_power_ctrl_chk #(
  .NPORT(NPORT), .SETTLE(SETTLE), .IDLE_MIN(IDLE_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .notice_in(notice_in), .pkt_arrive(pkt_arrive),
  .inject_req(inject_req), .buf_nonempty(buf_nonempty), .hot(hot),
  .vdd_high(vdd_high), .pipe_short(pipe_short)
);

// File: tb/vp_power_ctrl_test.sv
`timescale 1ns/1ps
module vp_power_ctrl_test;
  localparam int NP  = 5;
  localparam int SET = 2;
  localparam int IDL = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] notice_in = '0, pkt_arrive = '0, buf_nonempty = '0;
  logic          inject_req = 1'b0, hot = 1'b0, perf_policy = 1'b0;
  logic          vdd_high, pipe_short, notice_out;
  int            checks = 0, errors = 0;

  always #10 clk = ~clk;

  vp_power_ctrl #(.NPORT(NP), .SETTLE(SET), .IDLE_MIN(IDL)) uut (
    .clk(clk), .rst_n(rst_n), .notice_in(notice_in), .pkt_arrive(pkt_arrive),
    .inject_req(inject_req), .buf_nonempty(buf_nonempty), .hot(hot),
    .perf_policy(perf_policy), .vdd_high(vdd_high), .pipe_short(pipe_short),
    .notice_out(notice_out)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic legal();
    chk("R4", "short_on_low", pipe_short && !vdd_high, 1'b0);
  endtask

  task automatic clear_in();
    notice_in = '0; pkt_arrive = '0; buf_nonempty = '0; inject_req = 1'b0;
  endtask

  task automatic settle_low();
    clear_in();
    for (int i = 0; i < IDL + 2*SET + 8; i++) tick();
    chk("R6", "vdd_parked", vdd_high, 1'b0);
    chk("R6", "short_parked", pipe_short, 1'b0);
  endtask

  task automatic apply(int kind, int idx, logic on);
    clear_in();
    case (kind)
      0: notice_in[idx] = on;
      1: pkt_arrive[idx] = on;
      2: inject_req = on;
      default: buf_nonempty[idx] = on;
    endcase
  endtask

  task automatic run_burst(int kind, int idx, int last);
    for (int i = 0; i <= last + IDL + 6; i++) begin
      apply(kind, idx, i <= last);
      tick();
      begin
        int j = i + 1;
        logic ev = (j >= 1) && (j <= last + IDL + 2);
        logic es = (j >= SET + 1) && (j <= last + IDL + 1);
        logic en = (kind == 1 || kind == 2) && (j - 1 <= last);
        chk(j == 1 ? "R2" : "R5", "vdd", vdd_high, ev);
        chk(j <= SET + 1 ? "R3" : "R6", "short", pipe_short, es);
        chk("R10", "notice_out", notice_out, en);
        legal();
      end
    end
    clear_in();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    chk("R1", "vdd_in_reset", vdd_high, 1'b0);
    chk("R1", "short_in_reset", pipe_short, 1'b0);
    chk("R1", "notice_in_reset", notice_out, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1", "vdd_after_reset", vdd_high, 1'b0);
    chk("R1", "short_after_reset", pipe_short, 1'b0);
    chk("R1", "notice_after_reset", notice_out, 1'b0);

    for (int kind = 0; kind < 4; kind++)
      for (int idx = 0; idx < NP; idx++) begin
        if (kind == 2 && idx > 0) continue;
        run_burst(kind, idx, 0);
        settle_low();
        run_burst(kind, idx, 7);
        settle_low();
      end
    run_burst(3, 2, 30);
    settle_low();

    // R7: cancel in the long-pipeline high step
    notice_in[1] = 1'b1; tick(); clear_in();
    for (int j = 2; j <= IDL + 2; j++) tick();
    chk("R5", "lengthened_short", pipe_short, 1'b0);
    chk("R5", "lengthened_vdd", vdd_high, 1'b1);
    notice_in[3] = 1'b1; tick(); clear_in();
    chk("R7", "cancel_short", pipe_short, 1'b1);
    chk("R7", "cancel_vdd", vdd_high, 1'b1);
    settle_low();

    // R7: cancel just after the rail drops
    notice_in[0] = 1'b1; tick(); clear_in();
    for (int j = 2; j <= IDL + 3; j++) tick();
    chk("R5", "lowered_vdd", vdd_high, 1'b0);
    notice_in[4] = 1'b1; tick(); clear_in();
    chk("R7", "reraise_vdd", vdd_high, 1'b1);
    chk("R7", "reraise_short", pipe_short, 1'b0);
    for (int j = 2; j <= SET; j++) tick();
    chk("R7", "resettle_short", pipe_short, 1'b0);
    legal();
    tick();
    chk("R7", "resettled_short", pipe_short, 1'b1);
    settle_low();

    // R8: hot from the low rail
    hot = 1'b1; notice_in[2] = 1'b1; tick(); clear_in();
    chk("R8", "hot_vdd", vdd_high, 1'b1);
    for (int j = 0; j < IDL + 6; j++) begin
      tick();
      chk("R8", "hot_short", pipe_short, 1'b0);
      chk("R8", "hot_vdd_hold", vdd_high, 1'b1);
    end
    hot = 1'b0; tick();
    chk("R8", "cool_release_vdd", vdd_high, 1'b0);
    settle_low();

    // R8: hot while on the short pipeline
    notice_in[0] = 1'b1; tick(); clear_in();
    for (int j = 2; j <= SET + 1; j++) tick();
    chk("R3", "pre_hot_short", pipe_short, 1'b1);
    hot = 1'b1; tick();
    chk("R8", "hot_cut_short", pipe_short, 1'b0);
    chk("R8", "hot_keep_vdd", vdd_high, 1'b1);
    hot = 1'b0;
    settle_low();

    // R9: performance policy
    perf_policy = 1'b1; tick();
    chk("R9", "perf_vdd", vdd_high, 1'b1);
    for (int j = 2; j <= SET + 1; j++) tick();
    chk("R9", "perf_short", pipe_short, 1'b1);
    for (int j = 0; j < 3 * IDL; j++) begin
      tick();
      chk("R9", "perf_hold", pipe_short, 1'b1);
    end
    perf_policy = 1'b0; tick();
    chk("R9", "perf_drop_short", pipe_short, 1'b0);
    chk("R9", "perf_drop_vdd_hold", vdd_high, 1'b1);
    tick();
    chk("R9", "perf_drop_vdd", vdd_high, 1'b0);
    settle_low();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule